// File: doc/BRIEF.md
# Three-Category Masked Interrupt Controller

This block gathers interrupt events from many sources into three status words: normal, external and error. Nine mask words, one for each pairing of a priority level with a category, select which status bits reach each of three level request outputs. A host CPU reads and clears status over a plain 32-bit word bus. The highest level drives CPU request line 9, the middle level line 11 and the lowest level line 13.

A source raises an event by presenting an identifier whose upper bits name the category and whose low byte names the bit. External sources can also withdraw a request through a cancel port. When one chosen normal event is raised, a one-cycle pulse goes to a peripheral interface.

Top module: `tri_cat_irq_ctrl`

## Requirements
- R1: After reset, every status and mask word reads zero, and all three request outputs and the side pulse are low.
- R2: A raise identifier is 10 bits. Bits 9:8 select the category (0 normal, 1 external, 2 error; 3 is ignored) and bits 7:0 give the bit index to set. An index of 32 or more sets nothing. A normal index of 30 or 31 sets nothing.
- R3: A read of bus word 0 (normal status) returns the stored normal bits in 29:0. Bit 30 is the OR of all external status bits and bit 31 is the OR of all error status bits.
- R4: Writes to bus word 0 (normal) and bus word 2 (error) clear each status bit written as 1 and leave bits written as 0 alone. Bits 31:30 of a normal write have no effect.
- R5: Writes to bus word 1 (external status) change nothing. An external bit clears only when the cancel port names its index.
- R6: The nine masks are at bus words 3 + 3*level + category, with level 0 = high, 1 = middle, 2 = low and categories numbered as in R2. Each is loaded whole by a write and reads back the value written.
- R7: A request output is high when, in any category, a status bit is set and that bit is set in the same category's mask for that output's level.
- R8: The request outputs are registered. They show the effect of a raise, a cancel, a status clear or a mask write from the clock edge that captures that input, and not before.
- R9: When a raise and a software clear (or a cancel) hit the same status bit in the same cycle, the bit ends set.
- R10: Raising normal index 5 (parameter SCAN_IDX) drives the side pulse high for exactly the one cycle after the capturing edge. The same index in another category gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Raise event strobe |
| raise_id | input | 10 | Category in 9:8, bit index in 7:0 |
| cancel_valid | input | 1 | External cancel strobe |
| cancel_idx | input | 5 | External bit to clear |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data for bus_addr (combinational) |
| req_hi | output | 1 | High level request (CPU line 9) |
| req_mid | output | 1 | Middle level request (CPU line 11) |
| req_lo | output | 1 | Low level request (CPU line 13) |
| scan_pulse | output | 1 | One-cycle side pulse for the chosen normal event |

## Verification
The status-to-request path is tried with one category at a time feeding one level. This shows that each category reaches only the level whose mask enables it. Events are then added in other categories while a mask stays unset, which tells correct masking apart from a plain OR of status. Identifiers with category 3, an index beyond the word, and normal indices 30 and 31 separate correct decoding from truncation. Raises that collide with clears or cancels in the same cycle tell set-priority from clear-priority. A check taken just before the capturing edge tells a registered output from a combinational one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned NUM_CAT   = 3;
   localparam int unsigned NUM_LVL   = 3;
   localparam int unsigned NUM_MASK  = NUM_CAT * NUM_LVL;
   localparam int unsigned MASK_BASE = 3;

   typedef enum logic [1:0] {
      CAT_NRM = 2'd0,
      CAT_EXT = 2'd1,
      CAT_ERR = 2'd2,
      CAT_BAD = 2'd3
   } cat_e;
endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] stat_d
);
   logic [W-1:0] set_eff;

   assign set_eff = set_vec & KEEP;
   // set is applied after clear so that a colliding raise wins
   assign stat_d  = ((stat_q & ~clr_vec) | set_eff) & KEEP;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assert_raise_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(set_eff)) == $past(set_eff)));
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_vec & ~set_eff)) == '0));
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q | set_eff)) == '0));
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
   parameter int unsigned W   = 32,
   parameter int unsigned NUM = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM-1:0]         wr_sel,
   input  logic [W-1:0]           wdata,
   output logic [NUM-1:0][W-1:0]  mask_q,
   output logic [NUM-1:0][W-1:0]  mask_d
);
   for (genvar k = 0; k < NUM; k++) begin : g_mask
      assign mask_d[k] = wr_sel[k] ? wdata : mask_q[k];

      always_ff @(posedge clk) begin
         if (!rst_n) mask_q[k] <= '0;
         else        mask_q[k] <= mask_d[k];
      end

      assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
         wr_sel[k] |=> (mask_q[k] == $past(wdata)));
      assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_sel[k] |=> $stable(mask_q[k]));
   end
endmodule

// File: rtl/irqc_level_combine.sv
module irqc_level_combine #(
   parameter int unsigned W       = 32,
   parameter int unsigned NUM_LVL = 3,
   parameter int unsigned NUM_CAT = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_CAT-1:0][W-1:0]        stat_n,
   input  logic [NUM_LVL*NUM_CAT-1:0][W-1:0] mask_n,
   output logic [NUM_LVL-1:0]               pend_q
);
   logic [NUM_LVL-1:0][NUM_CAT-1:0] hit;
   logic [NUM_CAT-1:0]              cat_any;

   for (genvar c = 0; c < NUM_CAT; c++) begin : g_any
      assign cat_any[c] = |stat_n[c];
   end

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
         assign hit[l][c] = |(stat_n[c] & mask_n[l*NUM_CAT + c]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[l] <= 1'b0;
         else        pend_q[l] <= |hit[l];
      end
   end

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_any == '0) |=> (pend_q == '0));
endmodule

// File: rtl/tri_cat_irq_ctrl.sv
module tri_cat_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned ID_W     = 10,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned SCAN_IDX = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raise_valid,
   input  logic [ID_W-1:0]   raise_id,
   input  logic              cancel_valid,
   input  logic [IDX_W-1:0]  cancel_idx,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              req_hi,
   output logic              req_mid,
   output logic              req_lo,
   output logic              scan_pulse
);
   localparam int unsigned NRM_W = DATA_W - 2;
   localparam logic [DATA_W-1:0] NRM_KEEP = {2'b00, {NRM_W{1'b1}}};
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   if (DATA_W < 8)             begin : g_bad_w   $error("DATA_W too small"); end
   if (ID_W != 10)             begin : g_bad_id  $error("ID_W must be 10"); end
   if ((1 << IDX_W) != DATA_W) begin : g_bad_idx $error("IDX_W must index DATA_W"); end
   if (SCAN_IDX >= NRM_W)      begin : g_bad_sc  $error("SCAN_IDX out of range"); end
   if ((1 << ADDR_W) < MASK_BASE + NUM_MASK) begin : g_bad_a $error("ADDR_W too small"); end

   // ---------------- raise decode ----------------
   cat_e        r_cat;
   logic [7:0]  r_idx;
   logic        r_in_rng;
   logic [DATA_W-1:0] r_bit;
   logic [NUM_CAT-1:0][DATA_W-1:0] set_vec;

   assign r_cat    = cat_e'(raise_id[9:8]);
   assign r_idx    = raise_id[7:0];
   assign r_in_rng = (32'(r_idx) < DATA_W);
   assign r_bit    = (raise_valid && r_in_rng) ? (ONE << r_idx) : '0;

   always_comb begin
      set_vec = '0;
      unique case (r_cat)
         CAT_NRM: set_vec[CAT_NRM] = r_bit;
         CAT_EXT: set_vec[CAT_EXT] = r_bit;
         CAT_ERR: set_vec[CAT_ERR] = r_bit;
         default: set_vec = '0;
      endcase
   end

   // ---------------- clear sources ----------------
   logic wr_nrm, wr_ext, wr_err;
   logic [NUM_CAT-1:0][DATA_W-1:0] clr_vec;

   assign wr_nrm = bus_wr && (bus_addr == ADDR_W'(CAT_NRM));
   assign wr_ext = bus_wr && (bus_addr == ADDR_W'(CAT_EXT));
   assign wr_err = bus_wr && (bus_addr == ADDR_W'(CAT_ERR));

   assign clr_vec[CAT_NRM] = wr_nrm ? (bus_wdata & NRM_KEEP) : '0;
   assign clr_vec[CAT_EXT] = cancel_valid ? (ONE << cancel_idx) : '0;
   assign clr_vec[CAT_ERR] = wr_err ? bus_wdata : '0;

   // ---------------- status banks ----------------
   logic [NUM_CAT-1:0][DATA_W-1:0] stat_q, stat_d;

   for (genvar c = 0; c < NUM_CAT; c++) begin : g_stat
      localparam logic [DATA_W-1:0] KEEP_C = (c == CAT_NRM) ? NRM_KEEP : '1;
      irqc_status_bank #(.W(DATA_W), .KEEP(KEEP_C)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_vec (set_vec[c]),
         .clr_vec (clr_vec[c]),
         .stat_q  (stat_q[c]),
         .stat_d  (stat_d[c])
      );
   end

   // ---------------- mask storage ----------------
   logic [NUM_MASK-1:0]              mask_sel;
   logic [NUM_MASK-1:0][DATA_W-1:0]  mask_q, mask_d;

   for (genvar k = 0; k < NUM_MASK; k++) begin : g_msel
      assign mask_sel[k] = bus_wr && (bus_addr == ADDR_W'(MASK_BASE + k));
   end

   irqc_mask_bank #(.W(DATA_W), .NUM(NUM_MASK)) i_masks (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (mask_sel),
      .wdata  (bus_wdata),
      .mask_q (mask_q),
      .mask_d (mask_d)
   );

   // ---------------- level combine ----------------
   logic [NUM_LVL-1:0] pend;

   irqc_level_combine #(.W(DATA_W), .NUM_LVL(NUM_LVL), .NUM_CAT(NUM_CAT)) i_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_n (stat_d),
      .mask_n (mask_d),
      .pend_q (pend)
   );

   assign req_hi  = pend[0];
   assign req_mid = pend[1];
   assign req_lo  = pend[2];

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CAT_NRM)) begin
         bus_rdata           = stat_q[CAT_NRM] & NRM_KEEP;
         bus_rdata[DATA_W-2] = |stat_q[CAT_EXT];
         bus_rdata[DATA_W-1] = |stat_q[CAT_ERR];
      end else if (bus_addr == ADDR_W'(CAT_EXT)) begin
         bus_rdata = stat_q[CAT_EXT];
      end else if (bus_addr == ADDR_W'(CAT_ERR)) begin
         bus_rdata = stat_q[CAT_ERR];
      end else begin
         for (int k = 0; k < NUM_MASK; k++) begin
            if (bus_addr == ADDR_W'(MASK_BASE + k)) bus_rdata = mask_q[k];
         end
      end
   end

   // ---------------- side pulse ----------------
   logic scan_hit;
   assign scan_hit = raise_valid && (r_cat == CAT_NRM) && (32'(r_idx) == SCAN_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) scan_pulse <= 1'b0;
      else        scan_pulse <= scan_hit;
   end

   assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      scan_pulse |-> $past(raise_valid));
   assert_ext_sw_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ext && !raise_valid && !cancel_valid) |=> $stable(stat_q[CAT_EXT]));
   assert_nrm_top_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_q[CAT_NRM][DATA_W-1:DATA_W-2] == 2'b00));
endmodule

// File: tb/test_tri_cat_irq_ctrl.sv
module test_tri_cat_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 13;

   typedef struct packed {
      logic [1:0]  op;    // 0 write, 1 raise, 2 cancel
      logic [15:0] arg;
      logic [31:0] data;
      logic [3:0]  chk;
      logic [31:0] exp;
      logic [2:0]  pend;  // {hi, mid, lo}
   } vec_t;

   localparam vec_t VECS [NV] = '{
      {2'd0, 16'd3,     32'h1,        4'd3, 32'h1,        3'b000},
      {2'd1, 16'h000,   32'h0,        4'd0, 32'h1,        3'b100},
      {2'd1, 16'h104,   32'h0,        4'd0, 32'h40000001, 3'b100},
      {2'd0, 16'd7,     32'h10,       4'd7, 32'h10,       3'b110},
      {2'd0, 16'd1,     32'hFFFFFFFF, 4'd1, 32'h10,       3'b110},
      {2'd2, 16'd4,     32'h0,        4'd1, 32'h0,        3'b100},
      {2'd1, 16'h21F,   32'h0,        4'd0, 32'h80000001, 3'b100},
      {2'd0, 16'd11,    32'h80000000, 4'd2, 32'h80000000, 3'b101},
      {2'd0, 16'd0,     32'hC0000001, 4'd0, 32'h80000000, 3'b001},
      {2'd0, 16'd2,     32'h80000000, 4'd0, 32'h0,        3'b000},
      {2'd1, 16'h31F,   32'h0,        4'd2, 32'h0,        3'b000},
      {2'd1, 16'h020,   32'h0,        4'd0, 32'h0,        3'b000},
      {2'd1, 16'h01E,   32'h0,        4'd0, 32'h0,        3'b000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raise_valid = 1'b0;
   logic [9:0]  raise_id = '0;
   logic        cancel_valid = 1'b0;
   logic [4:0]  cancel_idx = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_hi, req_mid, req_lo, scan_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tri_cat_irq_ctrl i_tri_cat_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .raise_valid(raise_valid), .raise_id(raise_id),
      .cancel_valid(cancel_valid), .cancel_idx(cancel_idx),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .req_hi(req_hi), .req_mid(req_mid), .req_lo(req_lo),
      .scan_pulse(scan_pulse)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle_inputs();
      raise_valid = 1'b0; cancel_valid = 1'b0; bus_wr = 1'b0;
   endtask

   // inputs are set, captured at the next rising edge, and released on the falling edge
   task automatic step(logic [3:0] rd_addr);
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      bus_addr = rd_addr;
      #1;
   endtask

   task automatic read_word(logic [3:0] a, logic [31:0] exp, string req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1: reset state on every word and output
      for (int a = 0; a < 12; a++) read_word(4'(a), 32'h0, "R1 reset word");
      check("R1 req outputs", {29'd0, req_hi, req_mid, req_lo}, 32'h0);
      check("R1 scan pulse", {31'd0, scan_pulse}, 32'h0);

      // table walk: R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         unique case (VECS[v].op)
            2'd0: begin bus_wr = 1'b1; bus_addr = VECS[v].arg[3:0]; bus_wdata = VECS[v].data; end
            2'd1: begin raise_valid = 1'b1; raise_id = VECS[v].arg[9:0]; end
            default: begin cancel_valid = 1'b1; cancel_idx = VECS[v].arg[4:0]; end
         endcase
         step(VECS[v].chk);
         check($sformatf("R3 vector %0d rdata", v), bus_rdata, VECS[v].exp);
         check($sformatf("R7 vector %0d req", v), {29'd0, req_hi, req_mid, req_lo},
               {29'd0, VECS[v].pend});
      end

      // R6: another mask word loads and reads back
      bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'hA5;
      step(4'd5);
      check("R6 mask readback", bus_rdata, 32'hA5);

      // R9: raise and software clear on the same normal bit
      bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h4;
      step(4'd0);
      raise_valid = 1'b1; raise_id = 10'h002;
      bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h4;
      step(4'd0);
      check("R9 raise beats clear", bus_rdata, 32'h4);
      check("R9 req_hi", {31'd0, req_hi}, 32'h1);

      // R9: raise and cancel on the same external bit (mask mid ext = 0x10)
      raise_valid = 1'b1; raise_id = 10'h104;
      cancel_valid = 1'b1; cancel_idx = 5'd4;
      step(4'd1);
      check("R9 raise beats cancel", bus_rdata, 32'h10);
      check("R9 req_mid", {31'd0, req_mid}, 32'h1);

      // R5: cancel of a different index leaves bit 4
      cancel_valid = 1'b1; cancel_idx = 5'd3;
      step(4'd1);
      check("R5 other cancel", bus_rdata, 32'h10);
      cancel_valid = 1'b1; cancel_idx = 5'd4;
      step(4'd1);
      check("R5 cancel clears", bus_rdata, 32'h0);

      // R8: request changes only at the capturing edge
      bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h4;
      #1;
      check("R8 before edge", {31'd0, req_hi}, 32'h1);
      step(4'd0);
      check("R8 after edge", {31'd0, req_hi}, 32'h0);

      // R4: partial clear of error bits
      raise_valid = 1'b1; raise_id = 10'h200;
      step(4'd2);
      raise_valid = 1'b1; raise_id = 10'h201;
      step(4'd2);
      bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h1;
      step(4'd2);
      check("R4 error partial clear", bus_rdata, 32'h2);

      // R10: side pulse on normal index 5 only
      raise_valid = 1'b1; raise_id = 10'h005;
      step(4'd0);
      check("R10 pulse high", {31'd0, scan_pulse}, 32'h1);
      @(negedge clk); #1;
      check("R10 pulse one cycle", {31'd0, scan_pulse}, 32'h0);
      raise_valid = 1'b1; raise_id = 10'h105;
      step(4'd0);
      check("R10 no pulse other category", {31'd0, scan_pulse}, 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule